// File: doc/BRIEF.md
# Wraparound Bit-Range Mask Generator

This block turns a pair of bit indices into a 64-bit mask, as needed beside a rotator that extracts or inserts a field of a word. Bits are numbered from the most significant end: index 0 names the MSB and index 63 names the LSB. The mask carries ones from the start index to the stop index inclusive. When the start index is greater than the stop index, the ones run from the start index to the end of the word and then continue from index 0 up to the stop index. The bits between the two runs stay zero.

A parameter selects one of two variants. In the combinational variant the mask follows the indices within the same cycle, and the valid output simply repeats the valid input. In the registered variant the mask is captured one clock after a valid input and held until the next valid input, with a one-cycle valid pulse. After reset the registered mask is all zeros.

Top module: `mask_range_gen`

## Requirements
- R1: When start <= stop, mask bits at indices start through stop inclusive are one and every other bit is zero.
- R2: When start > stop, bits at indices start..63 and 0..stop are one and the indices strictly between stop and start are zero.
- R3: Index i maps to mask_o[63-i], so index 0 is the MSB (mask_o[63]) and index 63 is the LSB (mask_o[0]).
- R4: When start equals stop, exactly one mask bit is set.
- R5: When start equals stop+1, and also when start is 0 and stop is 63, the mask is all ones.
- R6: In the registered variant, while rst_n is low and after reset until the first valid input, mask_o is all zeros and out_valid is 0.
- R7: In the registered variant, the mask for indices presented with in_valid high appears on mask_o one clock later, and out_valid is high in exactly that cycle.
- R8: In the registered variant, index changes while in_valid is low leave mask_o unchanged and out_valid low.
- R9: In the combinational variant (REGISTERED=0), mask_o reflects the current indices in the same cycle and out_valid equals in_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Indices are valid this cycle |
| start_idx | input | 6 | First index of the ones run, MSB-first |
| stop_idx | input | 6 | Last index of the ones run, MSB-first |
| mask_o | output | 64 | Generated mask |
| out_valid | output | 1 | Mask on mask_o is new this cycle |

## Verification
The assertions check the population count of every produced mask against the range length, including the wrapping case. They also check the single-bit case, the all-ones case, the one-cycle timing of the valid pulse, and that the mask holds while no valid input arrives. These checks run on every cycle. A count cannot show where the ones sit, so only the bench's scenarios confirm the exact bit positions. These include MSB-first numbering, the zero gap in a wrapped mask and the reset value. The bench compares each mask against a fixed table and against a per-bit reference.

// File: rtl/mask_range_gen.sv
module mask_range_gen #(
  parameter int W          = 64,
  parameter bit REGISTERED = 1'b1,
  localparam int IW        = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] start_idx,
  input  logic [IW-1:0] stop_idx,
  output logic [W-1:0]  mask_o,
  output logic          out_valid
);

  localparam logic [IW-1:0] LAST = IW'(W - 1);

  logic [W-1:0] ones;
  logic [W-1:0] from_start;
  logic [W-1:0] upto_stop;
  logic         wraps;
  logic [W-1:0] mask_c;

  assign ones       = '1;
  assign from_start = ones >> start_idx;
  assign upto_stop  = ones << (LAST - stop_idx);
  assign wraps      = start_idx > stop_idx;
  assign mask_c     = wraps ? (from_start | upto_stop) : (from_start & upto_stop);

  function automatic int run_len(input int s, input int e);
    return (s > e) ? (W - s + e + 1) : (e - s + 1);
  endfunction

  generate
    if (REGISTERED) begin : g_reg
      logic [W-1:0] mask_q;
      logic         vld_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mask_q <= '0;
          vld_q  <= 1'b0;
        end else begin
          vld_q <= in_valid;
          if (in_valid) mask_q <= mask_c;
        end
      end

      assign mask_o    = mask_q;
      assign out_valid = vld_q;

      a_r7_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
      a_r7_count_matches_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(mask_o) == run_len(int'($past(start_idx)), int'($past(stop_idx))));
      a_r8_hold_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(mask_o) && !out_valid);
      a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && start_idx == stop_idx) |=> $onehot(mask_o));
      a_r5_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && start_idx == stop_idx + 1'b1) |=> &mask_o);
    end else begin : g_comb
      assign mask_o    = mask_c;
      assign out_valid = in_valid;

      a_r9_count_matches_range: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $countones(mask_o) == run_len(int'(start_idx), int'(stop_idx)));
      a_r4_single_bit_comb: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && start_idx == stop_idx) |-> $onehot(mask_o));
    end
  endgenerate

endmodule

// File: tb/mask_range_gen_tb.sv
module mask_range_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  start_idx = '0;
  logic [5:0]  stop_idx = '0;
  logic [63:0] mask_r, mask_c;
  logic        vld_r, vld_c;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  mask_range_gen #(.W(64), .REGISTERED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .start_idx(start_idx),
    .stop_idx(stop_idx), .mask_o(mask_r), .out_valid(vld_r));

  mask_range_gen #(.W(64), .REGISTERED(1'b0)) u_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .start_idx(start_idx),
    .stop_idx(stop_idx), .mask_o(mask_c), .out_valid(vld_c));

  localparam int NV = 10;
  localparam logic [5:0] TS [NV] = '{6'd0, 6'd0, 6'd63, 6'd4, 6'd60, 6'd32, 6'd1, 6'd63, 6'd8, 6'd16};
  localparam logic [5:0] TE [NV] = '{6'd63, 6'd0, 6'd63, 6'd7, 6'd3, 6'd31, 6'd0, 6'd0, 6'd15, 6'd47};
  localparam logic [63:0] TM [NV] = '{
    64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001,
    64'h0F00_0000_0000_0000, 64'hF000_0000_0000_000F, 64'hFFFF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 64'h00FF_0000_0000_0000,
    64'h0000_FFFF_FFFF_0000};

  function automatic logic [63:0] ref_mask(input int s, input int e);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++) begin
      if ((s <= e) ? (i >= s && i <= e) : (i >= s || i <= e)) m[63 - i] = 1'b1;
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input int s, input int e, input logic [63:0] exp);
    @(negedge clk);
    start_idx = 6'(s);
    stop_idx  = 6'(e);
    in_valid  = 1'b1;
    #1;
    check({req, " R9 comb mask"}, mask_c, exp);
    check("R9 comb valid", {63'd0, vld_c}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R7 reg mask"}, mask_r, exp);
    check("R7 reg valid", {63'd0, vld_r}, 64'd1);
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual %0d expected <20000 cycles", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset mask", mask_r, 64'd0);
    check("R6 reset valid", {63'd0, vld_r}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 post-reset mask", mask_r, 64'd0);

    for (int k = 0; k < NV; k++) apply("R1 R2 R3 table", int'(TS[k]), int'(TE[k]), TM[k]);

    apply("R3 msb", 0, 0, 64'h8000_0000_0000_0000);
    apply("R4 single", 37, 37, 64'd1 << 26);
    apply("R5 wrap full", 10, 9, '1);
    apply("R2 wrap gap", 50, 5, ref_mask(50, 5));
    apply("R1 plain", 5, 50, ref_mask(5, 50));

    @(negedge clk);
    check("R7 valid one cycle", {63'd0, vld_r}, 64'd0);
    start_idx = 6'd20;
    stop_idx  = 6'd22;
    @(negedge clk);
    @(negedge clk);
    check("R8 held mask", mask_r, ref_mask(5, 50));
    check("R8 no valid", {63'd0, vld_r}, 64'd0);
    check("R9 comb valid low", {63'd0, vld_c}, 64'd0);

    for (int s = 0; s < 64; s += 7)
      for (int e = 0; e < 64; e += 9)
        apply("R1 R2 sweep", s, e, ref_mask(s, e));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule